// File: doc/BRIEF.md
# BCD to Seven-Segment Driver with Input Hold

This block turns one four-bit binary-coded decimal digit into seven segment drive lines for a common-cathode display, where a high level lights a segment. Two active-low overrides sit in front of the decoded pattern. Lamp test lights every segment, so a display can be checked for dead segments. Blanking darkens the whole digit. Input codes that are not decimal digits darken the display instead of showing a false glyph.

An active-high hold input freezes the digit being shown. While hold is low, the block passes the digit input straight through. While hold is high, it keeps showing the last digit taken while hold was low, so upstream logic can change the digit bus freely. The segment outputs come from a register clocked by the system clock. Each input change therefore appears on the segments one clock edge later. A synchronous active-high reset darkens the segments and clears the held digit to zero.

Top module: `seg7_bcd_driver`

## Requirements
- R1: While `rst` is high at a clock edge, `seg` is 0 after that edge, and the held digit is cleared to 0. If `hold` stays high after reset, with the overrides inactive, the display shows the glyph for 0 (7'h3F).
- R2: `digit[0]` has weight 1 and `digit[3]` has weight 8. `seg[0]` drives segment a, and the following bits drive b, c, d, e, f and g in that order up to `seg[6]`. A 1 lights a segment.
- R3: With both overrides inactive, codes 0 to 9 produce these patterns: 0 lights abcdef, 1 lights bc, 2 lights abdeg, 3 lights abcdg, 4 lights bcfg, 5 lights acdfg, 6 lights acdefg, 7 lights abc, 8 lights all seven, and 9 lights abcdfg.
- R4: With both overrides inactive, codes 10 to 15 drive `seg` to 0.
- R5: When `lamp_test_n` is 0 at a clock edge, `seg` is 7'h7F after that edge, whatever the other inputs are.
- R6: When `blank_n` is 0 and `lamp_test_n` is 1 at a clock edge, `seg` is 0 after that edge.
- R7: While `hold` is 0, `seg` after an edge reflects `digit` as sampled at that edge: one edge of latency, with no change between edges.
- R8: While `hold` is 1, `seg` shows the digit captured at the last edge where `hold` was 0, and changes on `digit` have no effect.
- R9: Lamp test and blanking do not disturb the held digit. When both overrides are released while `hold` stays 1, the held glyph returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| digit | input | DIGIT_W (4) | BCD digit, bit 0 least significant |
| hold | input | 1 | Active-high hold; low passes `digit` through, high keeps the last digit |
| lamp_test_n | input | 1 | Active-low lamp test, lights every segment |
| blank_n | input | 1 | Active-low blanking, darkens every segment |
| seg | output | 7 | Registered segment drives, bit 0 = a through bit 6 = g, high lights |

## Verification
The assertions assume that reset is high at the first clock edge. They also assume that every input is settled at each rising edge, since each property relates the inputs sampled at one edge to `seg` one edge later. The bench meets both conditions: it holds `rst` high from time zero and changes every input only at falling edges. Within those limits it sweeps all 16 codes under every combination of lamp test and blanking with hold low. For every held code, it then toggles the digit bus and both overrides while hold stays high.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int SEG_N = 7;
  typedef logic [SEG_N-1:0] seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_N{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_N{1'b0}};

  // bit positions of the segment letters in seg_t
  localparam int SEG_A = 0;
  localparam int SEG_B = 1;
  localparam int SEG_C = 2;
  localparam int SEG_D = 3;
  localparam int SEG_E = 4;
  localparam int SEG_F = 5;
  localparam int SEG_G = 6;

  typedef enum logic [1:0] {
    DRV_GLYPH = 2'd0,
    DRV_LAMP  = 2'd1,
    DRV_DARK  = 2'd2
  } drive_mode_t;
endpackage

// File: rtl/seg7_input_hold.sv
module seg7_input_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_eff
);
  logic [W-1:0] held_q;

  // capture every edge while the hold is open
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (!hold) begin
      held_q <= d_in;
    end
  end

  // transparent while open, frozen while holding
  assign d_eff = hold ? held_q : d_in;
endmodule

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] code,
  output seg_t         glyph
);
  logic upper_nz;
  seg_t low_glyph;

  generate
    if (W > 4) begin : g_wide
      assign upper_nz = |code[W-1:4];
    end else begin : g_narrow
      assign upper_nz = 1'b0;
    end
  endgenerate

  always_comb begin
    case (code[3:0])
      4'd0:    low_glyph = 7'h3F;
      4'd1:    low_glyph = 7'h06;
      4'd2:    low_glyph = 7'h5B;
      4'd3:    low_glyph = 7'h4F;
      4'd4:    low_glyph = 7'h66;
      4'd5:    low_glyph = 7'h6D;
      4'd6:    low_glyph = 7'h7D;
      4'd7:    low_glyph = 7'h07;
      4'd8:    low_glyph = 7'h7F;
      4'd9:    low_glyph = 7'h6F;
      default: low_glyph = SEG_ALL_OFF;
    endcase
  end

  assign glyph = upper_nz ? SEG_ALL_OFF : low_glyph;
endmodule

// File: rtl/seg7_override.sv
module seg7_override
  import seg7_pkg::*;
(
  input  logic lamp_test_n,
  input  logic blank_n,
  input  seg_t glyph,
  output seg_t seg_next
);
  drive_mode_t mode;

  // lamp test outranks blanking
  always_comb begin
    if (!lamp_test_n)  mode = DRV_LAMP;
    else if (!blank_n) mode = DRV_DARK;
    else               mode = DRV_GLYPH;
  end

  always_comb begin
    case (mode)
      DRV_LAMP:  seg_next = SEG_ALL_ON;
      DRV_DARK:  seg_next = SEG_ALL_OFF;
      default:   seg_next = glyph;
    endcase
  end
endmodule

// File: rtl/seg7_bcd_driver.sv
module seg7_bcd_driver
  import seg7_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit,
  input  logic               hold,
  input  logic               lamp_test_n,
  input  logic               blank_n,
  output logic [SEG_N-1:0]   seg
);
  logic [DIGIT_W-1:0] code_eff;
  seg_t               glyph;
  seg_t               seg_next;
  seg_t               seg_q;

  seg7_input_hold #(.W(DIGIT_W)) hold_i (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold),
    .d_in  (digit),
    .d_eff (code_eff)
  );

  seg7_glyph_rom #(.W(DIGIT_W)) rom_i (
    .code  (code_eff),
    .glyph (glyph)
  );

  seg7_override ovr_i (
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .glyph       (glyph),
    .seg_next    (seg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) seg_q <= SEG_ALL_OFF;
    else     seg_q <= seg_next;
  end

  assign seg = seg_q;
endmodule

// File: rtl/seg7_bcd_driver_chk.sv
module seg7_bcd_driver_chk #(
  parameter int DIGIT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [DIGIT_W-1:0] digit,
  input logic               hold,
  input logic               lamp_test_n,
  input logic               blank_n,
  input logic [6:0]         seg
);
  // R1
  reset_dark_chk: assert property (@(posedge clk) rst |=> (seg == 7'h00));

  // R5
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    !lamp_test_n |=> (seg == 7'h7F));

  // R6
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_test_n && !blank_n) |=> (seg == 7'h00));

  // R4
  non_bcd_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_test_n && blank_n && !hold && (digit > DIGIT_W'(9))) |=> (seg == 7'h00));

  // R3
  bcd_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (lamp_test_n && blank_n && !hold && (digit <= DIGIT_W'(9))) |=> (seg != 7'h00));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && lamp_test_n && blank_n && !$past(rst) &&
     $past(hold && lamp_test_n && blank_n)) |=> $stable(seg));
endmodule

bind seg7_bcd_driver seg7_bcd_driver_chk #(.DIGIT_W(DIGIT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .digit       (digit),
  .hold        (hold),
  .lamp_test_n (lamp_test_n),
  .blank_n     (blank_n),
  .seg         (seg)
);

// File: tb/seg7_bcd_driver_tb_top.sv
module seg7_bcd_driver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit = 4'd5;
  logic       hold = 1'b1;
  logic       lamp_test_n = 1'b1;
  logic       blank_n = 1'b1;
  logic [6:0] seg;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg7_bcd_driver dut_i (
    .clk         (clk),
    .rst         (rst),
    .digit       (digit),
    .hold        (hold),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .seg         (seg)
  );

  // glyph from per-segment lighting rules (R2, R3, R4); bit 0 = a ... bit 6 = g
  function automatic logic [6:0] glyph_of(input int v);
    logic [6:0] g;
    if (v > 9) return 7'h00;
    g[0] = !(v == 1 || v == 4);
    g[1] = !(v == 5 || v == 6);
    g[2] = (v != 2);
    g[3] = !(v == 1 || v == 4 || v == 7);
    g[4] = (v == 0 || v == 2 || v == 6 || v == 8);
    g[5] = !(v == 1 || v == 2 || v == 3 || v == 7);
    g[6] = !(v == 0 || v == 1 || v == 7);
    return g;
  endfunction

  function automatic logic [6:0] expect_seg(input logic lt, input logic bl, input int v);
    if (!lt) return 7'h7F;
    if (!bl) return 7'h00;
    return glyph_of(v);
  endfunction

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: seg actual %h expected %h", tag, got, exp);
    end
  endtask

  // drive at the falling edge, sample just after the next rising edge
  task automatic step(input logic [3:0] d, input logic h, input logic lt, input logic bl);
    @(negedge clk);
    digit = d; hold = h; lamp_test_n = lt; blank_n = bl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    string tag;
    // R1: reset darkens and clears the held digit
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", seg, 7'h00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 held cleared to 0", seg, 7'h3F);

    // R2: bit order of digit and seg
    step(4'b0001, 1'b0, 1'b1, 1'b1);
    check("R2 digit 0001", seg, 7'b0000110);
    step(4'b0010, 1'b0, 1'b1, 1'b1);
    check("R2 digit 0010", seg, 7'b1011011);

    // R7: no change between edges
    step(4'd3, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    digit = 4'd7;
    #1;
    check("R7 registered latency", seg, glyph_of(3));
    @(posedge clk);
    #1;
    check("R7 follows next edge", seg, glyph_of(7));

    // R3 R4 R5 R6: full sweep with hold open
    for (int lt = 0; lt < 2; lt++) begin
      for (int bl = 0; bl < 2; bl++) begin
        for (int v = 0; v < 16; v++) begin
          step(4'(v), 1'b0, 1'(lt), 1'(bl));
          if (lt == 0)      tag = "R5 lamp test";
          else if (bl == 0) tag = "R6 blank";
          else if (v > 9)   tag = "R4 non-BCD";
          else              tag = "R3 digit";
          check($sformatf("%s code %0d", tag, v), seg, expect_seg(1'(lt), 1'(bl), v));
        end
      end
    end

    // R8 R9: hold each code, disturb inputs
    for (int h = 0; h < 16; h++) begin
      step(4'(h), 1'b0, 1'b1, 1'b1);
      check($sformatf("R7 capture %0d", h), seg, glyph_of(h));
      step(4'((h + 5) % 16), 1'b1, 1'b1, 1'b1);
      check($sformatf("R8 hold %0d", h), seg, glyph_of(h));
      step(4'((h + 11) % 16), 1'b1, 1'b1, 1'b1);
      check($sformatf("R8 hold again %0d", h), seg, glyph_of(h));
      step(4'((h + 2) % 16), 1'b1, 1'b0, 1'b1);
      check($sformatf("R5 lamp during hold %0d", h), seg, 7'h7F);
      step(4'((h + 7) % 16), 1'b1, 1'b1, 1'b0);
      check($sformatf("R6 blank during hold %0d", h), seg, 7'h00);
      step(4'((h + 9) % 16), 1'b1, 1'b1, 1'b1);
      check($sformatf("R9 held restored %0d", h), seg, glyph_of(h));
    end

    // R1: reset during hold clears held value
    step(4'd9, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; hold = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset mid-run", seg, 7'h00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 held zero after reset", seg, 7'h3F);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule